// File: doc/BRIEF.md
# Multiplexed DRAM Row/Column Address Driver

This block turns one 16-bit access request into the pin sequence a 64K x 1 dynamic RAM expects. The 16-bit address is split in two halves that share a single 8-bit address bus. The low half (address bits 7..0) is the row. It goes out first and is latched into the memory by the falling edge of an active-low row strobe. The high half (bits 15..8) is the column. It follows on the same pins and is latched by an active-low column strobe. Writes drive the memory's data-in pin and its active-low write enable before the column strobe falls. Reads capture the memory's data-out pin a set number of cycles after the column strobe falls.

Each phase length is a parameter counted in clock cycles: row setup, row hold, column setup, column strobe width, read sample delay and precharge. After both strobes rise together, a precharge interval runs before the block accepts another request. The `ready` output shows when a request will be taken. Refresh scheduling is left to the surrounding logic.

Top module: `dram_addr_mux`

## Requirements
- R1: After a synchronous reset (including one in mid-access) `ready`=1, `ras_n`=1, `cas_n`=1, `we_n`=1, `rd_valid`=0 and `dram_a`=0.
- R2: A request is accepted on a rising edge where `req_valid`=1 and `ready`=1. From the next cycle, `dram_a` carries `req_addr[7:0]` with `ras_n` high for ROW_SETUP cycles. Then `ras_n` falls.
- R3: `ras_n` stays low with the row still on `dram_a` for ROW_HOLD cycles before the pins change.
- R4: `dram_a` then carries `req_addr[15:8]` for COL_SETUP cycles with `cas_n` high. It keeps that value for as long as `cas_n` is low. `cas_n` is only low while `ras_n` is low.
- R5: `cas_n` stays low for CAS_CYCLES cycles. After that, `ras_n` and `cas_n` both return to 1 on the same edge.
- R6: On a write (`req_write`=1), `we_n`=0 and `dram_d` equals the request's data bit from the start of column setup until the strobes rise. Otherwise `we_n`=1 and `dram_d`=0.
- R7: On a read, `dram_q` is captured on the clock edge SAMPLE_DLY cycles after the edge where `cas_n` fell. In the following cycle `rd_data` holds the captured bit and `rd_valid` is 1 for one cycle. Writes never raise `rd_valid`.
- R8: `ready` is 0 from the cycle after acceptance until PRECHARGE cycles after the strobes rise. A request presented while `ready`=0 is ignored and does not change the access in flight.
- R9: A request held at `req_valid`=1 when `ready` returns to 1 is accepted on that edge, with no idle cycle between accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address; row = bits 7..0, column = bits 15..8 |
| req_wdata | input | 1 | Bit to write |
| ready | output | 1 | Block will accept a request on this edge |
| dram_a | output | 8 | Multiplexed address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_d | output | 1 | Data-in pin of the memory |
| dram_q | input | 1 | Data-out pin of the memory |
| rd_data | output | 1 | Captured read bit |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` is new |

## Verification
The stimulus table mixes reads and writes with addresses whose two halves are clearly different (0x12A5, 0xA55A), complementary (0xFF00, 0x00FF), equal (0xFFFF) and sparse (0x8001). A row/column swap or a wrong half on the pins therefore shows up in some cycle.

The bench drives `dram_q` to the expected bit only in the single cycle before the intended capture edge, and to its complement in every other cycle. An off-by-one in the sample delay is therefore caught.

The vectors run back to back, so every access starts on the edge where `ready` returns. Directed cases add a request presented mid-access, which must leave the pins untouched, and a reset in mid-access.

// File: rtl/dram_mux_pkg.sv
// Shared types for the multiplexed DRAM address driver.
// Assumes a 16-bit word address split into two 8-bit halves.
package dram_mux_pkg;
    localparam int HALF_W = 8;
    localparam int ADDR_W = 2 * HALF_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ROW_SU,
        PH_RAS_HOLD,
        PH_COL_SU,
        PH_CAS_LOW,
        PH_PRECH
    } phase_e;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic              wdata;
    } req_t;
endpackage

// File: rtl/dram_phase_seq.sv
// Phase sequencer: accepts a request when idle, then walks the row setup,
// RAS hold, column setup, CAS low and precharge phases. Each phase lasts
// its parameter in cycles, and every length must be at least 1.
// It also flags the cycle at whose end the read data must be sampled.
module dram_phase_seq
    import dram_mux_pkg::*;
#(
    parameter int ROW_SETUP  = 2,
    parameter int ROW_HOLD   = 2,
    parameter int COL_SETUP  = 2,
    parameter int CAS_CYCLES = 3,
    parameter int SAMPLE_DLY = 2,
    parameter int PRECHARGE  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wdata,
    output phase_e            phase,
    output req_t              cur,
    output logic              sample_now
);
    localparam int MAX_A  = (ROW_SETUP > ROW_HOLD) ? ROW_SETUP : ROW_HOLD;
    localparam int MAX_B  = (COL_SETUP > CAS_CYCLES) ? COL_SETUP : CAS_CYCLES;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAXLEN = (MAX_C > PRECHARGE) ? MAX_C : PRECHARGE;
    localparam int CW     = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;
    localparam logic [CW-1:0] SAMPLE_CNT = CW'(CAS_CYCLES - SAMPLE_DLY);

    logic [CW-1:0] cnt;

    // Last count value of a phase (length minus one).
    function automatic logic [CW-1:0] last_of(input phase_e p);
        case (p)
            PH_ROW_SU:   return CW'(ROW_SETUP - 1);
            PH_RAS_HOLD: return CW'(ROW_HOLD - 1);
            PH_COL_SU:   return CW'(COL_SETUP - 1);
            PH_CAS_LOW:  return CW'(CAS_CYCLES - 1);
            PH_PRECH:    return CW'(PRECHARGE - 1);
            default:     return '0;
        endcase
    endfunction

    // Phase that follows a finished phase.
    function automatic phase_e next_of(input phase_e p);
        case (p)
            PH_ROW_SU:   return PH_RAS_HOLD;
            PH_RAS_HOLD: return PH_COL_SU;
            PH_COL_SU:   return PH_CAS_LOW;
            PH_CAS_LOW:  return PH_PRECH;
            default:     return PH_IDLE;
        endcase
    endfunction

    // Phase state, dwell counter and latched request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            cur   <= '0;
        end else if (phase == PH_IDLE) begin
            if (req_valid) begin
                cur   <= '{write: req_write, addr: req_addr, wdata: req_wdata};
                phase <= PH_ROW_SU;
                cnt   <= last_of(PH_ROW_SU);
            end
        end else if (cnt == '0) begin
            phase <= next_of(phase);
            cnt   <= last_of(next_of(phase));
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // Read sample strobe: the cycle ending SAMPLE_DLY edges after CAS fell.
    always_comb sample_now = (phase == PH_CAS_LOW) && !cur.write && (cnt == SAMPLE_CNT);
endmodule

// File: rtl/dram_pin_drive.sv
// Pin driver: decodes the current phase into the address-pin multiplex,
// the strobes and the write controls. It is purely combinational from
// sequencer registers, so every pin changes only on a clock edge.
module dram_pin_drive
    import dram_mux_pkg::*;
(
    input  phase_e            phase,
    input  req_t              cur,
    output logic [HALF_W-1:0] dram_a,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_d,
    output logic              ready
);
    logic row_on, col_on, wr_on;

    // Which address half is on the pins in this phase.
    always_comb begin
        row_on = (phase == PH_ROW_SU) || (phase == PH_RAS_HOLD);
        col_on = (phase == PH_COL_SU) || (phase == PH_CAS_LOW);
        wr_on  = col_on && cur.write;
    end

    // Address multiplexer: row = low half, column = high half.
    always_comb begin
        if (row_on)      dram_a = cur.addr[HALF_W-1:0];
        else if (col_on) dram_a = cur.addr[ADDR_W-1:HALF_W];
        else             dram_a = '0;
    end

    // Strobes, write controls and ready.
    always_comb begin
        dram_ras_n = !((phase == PH_RAS_HOLD) || col_on);
        dram_cas_n = (phase != PH_CAS_LOW);
        dram_we_n  = !wr_on;
        dram_d     = wr_on ? cur.wdata : 1'b0;
        ready      = (phase == PH_IDLE);
    end
endmodule

// File: rtl/dram_read_capture.sv
// Read capture: registers the memory data-out bit on the sample strobe
// and pulses a valid flag in the following cycle.
module dram_read_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_now,
    input  logic dram_q,
    output logic rd_data,
    output logic rd_valid
);
    // Capture register and one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= sample_now;
            if (sample_now) rd_data <= dram_q;
        end
    end
endmodule

// File: rtl/dram_addr_mux.sv
// Top: drives a 64K x 1 DRAM with a row-then-column multiplexed address.
// It accepts one request at a time when ready is high. Phase lengths are
// parameters in cycles; all must be >= 1 and SAMPLE_DLY <= CAS_CYCLES.
module dram_addr_mux #(
    parameter int ROW_SETUP  = 2,
    parameter int ROW_HOLD   = 2,
    parameter int COL_SETUP  = 2,
    parameter int CAS_CYCLES = 3,
    parameter int SAMPLE_DLY = 2,
    parameter int PRECHARGE  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic        req_wdata,
    output logic        ready,
    output logic [7:0]  dram_a,
    output logic        dram_ras_n,
    output logic        dram_cas_n,
    output logic        dram_we_n,
    output logic        dram_d,
    input  logic        dram_q,
    output logic        rd_data,
    output logic        rd_valid
);
    import dram_mux_pkg::*;

    phase_e phase;
    req_t   cur;
    logic   sample_now;

    dram_phase_seq #(
        .ROW_SETUP(ROW_SETUP), .ROW_HOLD(ROW_HOLD), .COL_SETUP(COL_SETUP),
        .CAS_CYCLES(CAS_CYCLES), .SAMPLE_DLY(SAMPLE_DLY), .PRECHARGE(PRECHARGE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .phase(phase), .cur(cur), .sample_now(sample_now)
    );

    dram_pin_drive u_pins (
        .phase(phase), .cur(cur), .dram_a(dram_a), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_d(dram_d),
        .ready(ready)
    );

    dram_read_capture u_rd (
        .clk(clk), .rst_n(rst_n), .sample_now(sample_now), .dram_q(dram_q),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: rtl/dram_addr_mux_chk.sv
// Protocol checker for dram_addr_mux, bound into every instance.
// It watches only the pins of the block.
module dram_addr_mux_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ready,
    input logic [7:0] dram_a,
    input logic       dram_ras_n,
    input logic       dram_cas_n,
    input logic       dram_we_n,
    input logic       rd_valid
);
    // R2: the row is steady across the RAS falling edge
    a_r2_row_stable_at_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> $stable(dram_a));

    // R4: CAS is only low while RAS is low
    a_r4_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    // R4: the column is steady while CAS stays low
    a_r4_col_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_a));

    // R5: both strobes rise together
    a_r5_strobes_rise_together: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_cas_n) |-> $rose(dram_ras_n));

    // R6: write enable is already low when CAS falls on a write
    a_r6_we_before_cas: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n));

    // R7: read valid is a single-cycle pulse
    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R8: a ready block has both strobes inactive
    a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (dram_ras_n && dram_cas_n && dram_we_n));
endmodule

bind dram_addr_mux dram_addr_mux_chk i_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .dram_a(dram_a),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .rd_valid(rd_valid)
);

// File: tb/test_dram_addr_mux.sv
// Bench: walks a vector table of back-to-back accesses and checks every
// pin in every cycle against timing derived from the requirements.
// Directed reset and ignored-request cases follow the table.
module test_dram_addr_mux;
    localparam int RS = 2, RH = 2, CS = 2, CC = 3, SD = 2, PR = 3;
    localparam int E_ROW = RS + RH;
    localparam int E_COL = E_ROW + CS;
    localparam int E_CAS = E_COL + CC;
    localparam int TOTAL = E_CAS + PR;
    localparam int C_SMP = E_COL + SD - 1;
    localparam int NV = 6;
    // {write, addr, wdata/qval}
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 16'h12A5, 1'b1},
        {1'b0, 16'hA55A, 1'b0},
        {1'b1, 16'hFF00, 1'b1},
        {1'b1, 16'h00FF, 1'b0},
        {1'b0, 16'hFFFF, 1'b1},
        {1'b1, 16'h8001, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0, dram_q = 1'b0;
    logic [15:0] req_addr = '0;
    logic ready, dram_ras_n, dram_cas_n, dram_we_n, dram_d, rd_data, rd_valid;
    logic [7:0] dram_a;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dram_addr_mux #(.ROW_SETUP(RS), .ROW_HOLD(RH), .COL_SETUP(CS),
        .CAS_CYCLES(CC), .SAMPLE_DLY(SD), .PRECHARGE(PR)) i_dram_addr_mux (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .dram_a(dram_a), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_d(dram_d), .dram_q(dram_q),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // One access; starts just after a negedge with ready=1, ends at a negedge.
    task automatic run_access(input logic wr, input logic [15:0] addr, input logic bitv,
                              input bit intrude);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = bitv;
        dram_q = ~bitv;
        @(posedge clk);
        for (int i = 1; i <= TOTAL + 1; i++) begin
            int c;
            logic xw;
            @(negedge clk);
            c  = i - 1;
            xw = wr && c >= E_ROW && c < E_CAS;
            if (c < E_ROW) chk("R2 row on pins", 16'(dram_a), 16'(addr[7:0]));
            else if (c < E_CAS) chk("R4 column on pins", 16'(dram_a), 16'(addr[15:8]));
            else chk("R8 pins idle", 16'(dram_a), 16'h0);
            chk("R3 ras_n", 16'(dram_ras_n), 16'((c >= RS && c < E_CAS) ? 1'b0 : 1'b1));
            chk("R5 cas_n", 16'(dram_cas_n), 16'((c >= E_COL && c < E_CAS) ? 1'b0 : 1'b1));
            chk("R6 we_n", 16'(dram_we_n), 16'(!xw));
            chk("R6 dram_d", 16'(dram_d), 16'(xw ? bitv : 1'b0));
            if (c == TOTAL) chk("R9 ready back", 16'(ready), 16'h1);
            else chk("R8 ready", 16'(ready), 16'h0);
            chk("R7 rd_valid", 16'(rd_valid), 16'(!wr && c == C_SMP + 1));
            if (!wr && c == C_SMP + 1) chk("R7 rd_data", 16'(rd_data), 16'(bitv));
            dram_q = (c == C_SMP) ? bitv : ~bitv;
            if (intrude && c >= 1 && c <= 4) begin
                req_valid = 1'b1; req_addr = ~addr; req_write = ~wr; req_wdata = ~bitv;
            end else begin
                req_valid = 1'b0; req_addr = addr; req_write = wr; req_wdata = bitv;
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ready", 16'(ready), 16'h1);
        chk("R1 ras_n", 16'(dram_ras_n), 16'h1);
        chk("R1 cas_n", 16'(dram_cas_n), 16'h1);
        chk("R1 we_n", 16'(dram_we_n), 16'h1);
        chk("R1 rd_valid", 16'(rd_valid), 16'h0);
        chk("R1 dram_a", 16'(dram_a), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // Table walk, back to back (R9)
        for (int v = 0; v < NV; v++)
            run_access(VEC[v][17], VEC[v][16:1], VEC[v][0], 1'b0);
        // R8: requests during a busy access are ignored
        run_access(1'b0, 16'h3C69, 1'b1, 1'b1);
        repeat (3) begin
            @(negedge clk);
            chk("R8 no access after ignored request", 16'(dram_ras_n), 16'h1);
        end
        // R1: reset in mid-access
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h5A5A; req_wdata = 1'b1;
        @(posedge clk);
        @(negedge clk); req_valid = 1'b0;
        repeat (E_COL) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset ras_n", 16'(dram_ras_n), 16'h1);
        chk("R1 mid reset cas_n", 16'(dram_cas_n), 16'h1);
        chk("R1 mid reset we_n", 16'(dram_we_n), 16'h1);
        chk("R1 mid reset ready", 16'(ready), 16'h1);
        rst_n = 1'b1;
        @(negedge clk);
        run_access(1'b0, 16'h0001, 1'b0, 1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule